// File: doc/BRIEF.md
# Banked Row Cache with Last-Read-Row Tracking

This block models the cache side of a DRAM that carries its own row cache. Each bank has a static row register that holds a full row, and each bank records the row it last loaded. A falling row strobe starts a cycle. The cycle type comes from the refresh-select and write/read inputs, sampled at that edge. A read cycle to a row that is not already cached opens the DRAM array and copies the whole row into that bank's register. A read to the row already recorded skips the array completely. After a read, data is fetched from the row register by column address alone, with or without the row strobe held low.

The column address passes through a latch that is transparent while the column strobe is high. The read data passes through a second latch that is transparent while the column strobe is low. Write cycles go to the DRAM array at the latched column. A write to a row that is currently cached also updates the cached word. A write-type cycle without any column pulse acts as an externally addressed refresh and leaves every cache and its recorded row as they were. A refresh-select cycle opens the row given by an internal counter. Cache reads continue while that refresh runs. The array is a small behavioural memory, and the `array_act`/`array_row` outputs show each array activation.

Top module: `cdram_row_cache`

## Requirements
- R1: The column address is taken from `addr[COL_W-1:0]` directly while `col_stb_n` is high. While `col_stb_n` is low, the column address is the value that was sampled at the last clock edge with `col_stb_n` high.
- R2: Read data shows the selected cache word directly while `col_stb_n` is low. While `col_stb_n` is high, read data holds the word captured at the last clock edge with `col_stb_n` low.
- R3: A read cycle starts on a row-strobe fall with `ref_n`=1 and `wr_rd`=0. If the row (`addr[ROW_W-1:0]`, bank = its top `BANK_W` bits) is not the recorded row of its bank, the cycle pulses `array_act` for one clock after the fall edge with `array_row` equal to that row. It also loads the row into the bank's cache and records the row.
- R4: A read cycle whose row equals its bank's recorded row gives no `array_act` pulse.
- R5: In a write cycle (`wr_rd`=1, `ref_n`=1 at the fall), exactly one array write takes place when `col_stb_n` and `we_n` both become low. It uses `wdata` at that clock and the latched column, and it is not repeated while both stay low.
- R6: A write to the row recorded in its bank also updates that bank's cached word, so later column reads return the new value.
- R7: A write cycle with no column-strobe pulse leaves every cache word and every recorded row unchanged, even with `we_n` low.
- R8: A fall with `ref_n`=0 pulses `array_act` with `array_row` equal to the internal counter. The counter starts at 0 after reset and then increments by one, wrapping. Cache reads by column address continue during this cycle.
- R9: `dq_en` is 1 only when `oe_n` is 0 and no write cycle is open. When `dq_en` is 0, `dq_o` is 0.
- R10: After reset, `dq_en`, `array_act` and `array_row` are 0, and the caches hold no recorded rows.
- R11: Each bank keeps its own cached row and recorded row. A read to another bank neither evicts them nor changes them, and column reads follow the bank of the most recent read cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| row_stb_n | input | 1 | Row strobe; its fall starts a cycle |
| col_stb_n | input | 1 | Column strobe, active low |
| wr_rd | input | 1 | Cycle direction at the row fall: 1 write, 0 read |
| ref_n | input | 1 | Counter refresh select at the row fall, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | ADDR_W | Multiplexed row / column address |
| wdata | input | DATA_W | Write data |
| dq_o | output | DATA_W | Read data |
| dq_en | output | 1 | Read data drive enable |
| array_act | output | 1 | One-clock pulse per array activation |
| array_row | output | ROW_W | Row of the latest activation |

## Verification
The bench targets the read to an already recorded row. A design that ignored the recorded row would show an activation there. A write cycle with no column pulse must leave the cache intact; a design that did not honour this would lose the cached row and re-open the array on the next read. A write into the cached row must be visible in the cache; a design that missed this would return stale data. The bench also moves the address while the column strobe is low and raises the strobe while the address changes. A latch of the wrong polarity would show the new column at once. It holds the write enable low across several clocks to catch a design that writes twice. Finally, it reads a second bank and then returns to the first, where a design with a single shared cache would have to reload.

// File: rtl/rc_pkg.sv
package rc_pkg;

   typedef enum logic [1:0] {
      CYC_NONE  = 2'd0,
      CYC_READ  = 2'd1,
      CYC_WRITE = 2'd2,
      CYC_CREF  = 2'd3
   } rc_cyc_e;

   function automatic rc_cyc_e rc_classify(input logic cref_n, input logic is_wr);
      if (!cref_n)
         return CYC_CREF;
      else if (is_wr)
         return CYC_WRITE;
      return CYC_READ;
   endfunction

endpackage

// File: rtl/rc_strobe_decode.sv
module rc_strobe_decode
   import rc_pkg::*;
#(
   parameter int ROW_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             row_stb_n,
   input  logic             col_stb_n,
   input  logic             we_n,
   input  logic             wr_rd,
   input  logic             ref_n,
   input  logic [ROW_W-1:0] row_in,
   output rc_cyc_e          cyc_start,
   output logic             write_mode,
   output logic [ROW_W-1:0] open_row,
   output logic             wr_trig
);

   logic row_prev;
   logic wr_cond;
   logic wr_prev;
   logic row_fall;

   assign row_fall  = row_prev & ~row_stb_n;
   assign cyc_start = row_fall ? rc_classify(ref_n, wr_rd) : CYC_NONE;
   assign wr_cond   = write_mode & ~col_stb_n & ~we_n;
   assign wr_trig   = wr_cond & ~wr_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_prev   <= 1'b1;
         wr_prev    <= 1'b0;
         write_mode <= 1'b0;
         open_row   <= '0;
      end else begin
         row_prev <= row_stb_n;
         wr_prev  <= wr_cond;
         if (row_stb_n) begin
            write_mode <= 1'b0;
         end else if (cyc_start == CYC_WRITE) begin
            write_mode <= 1'b1;
            open_row   <= row_in;
         end
      end
   end

endmodule

// File: rtl/rc_col_path.sv
module rc_col_path #(
   parameter int COL_W  = 9,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              col_stb_n,
   input  logic              oe_n,
   input  logic              write_mode,
   input  logic [COL_W-1:0]  col_in,
   input  logic [DATA_W-1:0] cache_word,
   output logic [COL_W-1:0]  eff_col,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_en
);

   logic [COL_W-1:0]  held_col;
   logic [DATA_W-1:0] held_data;
   logic [DATA_W-1:0] data_raw;

   assign eff_col  = col_stb_n ? col_in : held_col;
   assign data_raw = col_stb_n ? held_data : cache_word;
   assign dq_en    = ~oe_n & ~write_mode;
   assign dq_o     = dq_en ? data_raw : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         held_col  <= '0;
         held_data <= '0;
      end else begin
         if (col_stb_n)
            held_col <= col_in;
         else
            held_data <= cache_word;
      end
   end

endmodule

// File: rtl/rc_cache_bank.sv
module rc_cache_bank #(
   parameter int ROW_W  = 2,
   parameter int COL_W  = 9,
   parameter int DATA_W = 8,
   localparam int COLS  = 1 << COL_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   load,
   input  logic [ROW_W-1:0]       load_row,
   input  logic [COLS*DATA_W-1:0] load_data,
   input  logic                   wr_en,
   input  logic [COL_W-1:0]       wr_col,
   input  logic [DATA_W-1:0]      wr_data,
   input  logic [COL_W-1:0]       rd_col,
   output logic [DATA_W-1:0]      rd_word,
   output logic [ROW_W-1:0]       tag,
   output logic                   valid
);

   logic [DATA_W-1:0] line [COLS];

   assign rd_word = line[rd_col];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tag   <= '0;
         valid <= 1'b0;
         for (int c = 0; c < COLS; c++)
            line[c] <= '0;
      end else if (load) begin
         tag   <= load_row;
         valid <= 1'b1;
         for (int c = 0; c < COLS; c++)
            line[c] <= load_data[c*DATA_W +: DATA_W];
      end else if (wr_en) begin
         line[wr_col] <= wr_data;
      end
   end

endmodule

// File: rtl/rc_dram_model.sv
module rc_dram_model
   import rc_pkg::*;
#(
   parameter int ROW_W  = 2,
   parameter int COL_W  = 9,
   parameter int DATA_W = 8,
   localparam int ROWS  = 1 << ROW_W,
   localparam int COLS  = 1 << COL_W
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  rc_cyc_e                cyc_start,
   input  logic [ROW_W-1:0]       row_in,
   input  logic                   rd_hit,
   input  logic                   wr_trig,
   input  logic [ROW_W-1:0]       open_row,
   input  logic [COL_W-1:0]       wr_col,
   input  logic [DATA_W-1:0]      wr_data,
   output logic [COLS*DATA_W-1:0] row_data,
   output logic                   array_act,
   output logic [ROW_W-1:0]       array_row,
   output logic [ROW_W-1:0]       ref_cnt
);

   logic [DATA_W-1:0] mem [ROWS][COLS];

   always_comb begin
      for (int c = 0; c < COLS; c++)
         row_data[c*DATA_W +: DATA_W] = mem[row_in][c];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         array_act <= 1'b0;
         array_row <= '0;
         ref_cnt   <= '0;
         for (int r = 0; r < ROWS; r++)
            for (int c = 0; c < COLS; c++)
               mem[r][c] <= '0;
      end else begin
         array_act <= 1'b0;
         unique case (cyc_start)
            CYC_CREF: begin
               array_act <= 1'b1;
               array_row <= ref_cnt;
               ref_cnt   <= ref_cnt + 1'b1;
            end
            CYC_WRITE: begin
               array_act <= 1'b1;
               array_row <= row_in;
            end
            CYC_READ: begin
               if (!rd_hit) begin
                  array_act <= 1'b1;
                  array_row <= row_in;
               end
            end
            default: ;
         endcase
         if (wr_trig)
            mem[open_row][wr_col] <= wr_data;
      end
   end

endmodule

// File: rtl/cdram_row_cache.sv
module cdram_row_cache
   import rc_pkg::*;
#(
   parameter int ROW_W  = 2,
   parameter int BANK_W = 1,
   parameter int COL_W  = 9,
   parameter int DATA_W = 8,
   localparam int ADDR_W = (ROW_W > COL_W) ? ROW_W : COL_W,
   localparam int NBANK  = 1 << BANK_W,
   localparam int COLS   = 1 << COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              row_stb_n,
   input  logic              col_stb_n,
   input  logic              wr_rd,
   input  logic              ref_n,
   input  logic              we_n,
   input  logic              oe_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] dq_o,
   output logic              dq_en,
   output logic              array_act,
   output logic [ROW_W-1:0]  array_row
);

   if (BANK_W < 1 || BANK_W > ROW_W) begin : g_bad_bank
      $error("BANK_W must lie between 1 and ROW_W");
   end
   if (COL_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("COL_W and DATA_W must be positive");
   end

   logic [ROW_W-1:0]       row_in;
   logic [COL_W-1:0]       col_in;
   logic [BANK_W-1:0]      row_bank;
   rc_cyc_e                cyc_start;
   logic                   write_mode;
   logic [ROW_W-1:0]       open_row;
   logic                   wr_trig;
   logic [COL_W-1:0]       eff_col;
   logic [DATA_W-1:0]      cache_word;
   logic [COLS*DATA_W-1:0] row_data;
   logic [ROW_W-1:0]       ref_cnt;
   logic                   rd_hit;
   logic                   rd_start;
   logic                   cref_start;
   logic [BANK_W-1:0]      active_bank;

   logic [DATA_W-1:0]      bank_word [NBANK];
   logic [ROW_W-1:0]       bank_tag  [NBANK];
   logic [NBANK-1:0]       valid_vec;
   logic [NBANK*ROW_W-1:0] tag_vec;

   assign row_in     = addr[ROW_W-1:0];
   assign col_in     = addr[COL_W-1:0];
   assign row_bank   = row_in[ROW_W-1 -: BANK_W];
   assign rd_start   = (cyc_start == CYC_READ);
   assign cref_start = (cyc_start == CYC_CREF);
   assign rd_hit     = valid_vec[row_bank] && (bank_tag[row_bank] == row_in);
   assign cache_word = bank_word[active_bank];

   rc_strobe_decode #(.ROW_W(ROW_W)) u_dec (
      .clk       (clk),
      .rst_n     (rst_n),
      .row_stb_n (row_stb_n),
      .col_stb_n (col_stb_n),
      .we_n      (we_n),
      .wr_rd     (wr_rd),
      .ref_n     (ref_n),
      .row_in    (row_in),
      .cyc_start (cyc_start),
      .write_mode(write_mode),
      .open_row  (open_row),
      .wr_trig   (wr_trig)
   );

   rc_col_path #(.COL_W(COL_W), .DATA_W(DATA_W)) u_col (
      .clk       (clk),
      .rst_n     (rst_n),
      .col_stb_n (col_stb_n),
      .oe_n      (oe_n),
      .write_mode(write_mode),
      .col_in    (col_in),
      .cache_word(cache_word),
      .eff_col   (eff_col),
      .dq_o      (dq_o),
      .dq_en     (dq_en)
   );

   rc_dram_model #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .cyc_start (cyc_start),
      .row_in    (row_in),
      .rd_hit    (rd_hit),
      .wr_trig   (wr_trig),
      .open_row  (open_row),
      .wr_col    (eff_col),
      .wr_data   (wdata),
      .row_data  (row_data),
      .array_act (array_act),
      .array_row (array_row),
      .ref_cnt   (ref_cnt)
   );

   for (genvar b = 0; b < NBANK; b++) begin : g_bank
      logic load_b;
      logic wr_b;
      logic valid_b;

      assign load_b = rd_start && !rd_hit && (row_bank == BANK_W'(b));
      assign wr_b   = wr_trig && valid_b && (bank_tag[b] == open_row);
      assign valid_vec[b] = valid_b;
      assign tag_vec[b*ROW_W +: ROW_W] = bank_tag[b];

      rc_cache_bank #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .load     (load_b),
         .load_row (row_in),
         .load_data(row_data),
         .wr_en    (wr_b),
         .wr_col   (eff_col),
         .wr_data  (wdata),
         .rd_col   (eff_col),
         .rd_word  (bank_word[b]),
         .tag      (bank_tag[b]),
         .valid    (valid_b)
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         active_bank <= '0;
      else if (rd_start)
         active_bank <= row_bank;
   end

endmodule

// File: rtl/cdram_row_cache_chk.sv
module cdram_row_cache_chk #(
   parameter int ROW_W = 2,
   parameter int NBANK = 2
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   oe_n,
   input logic                   dq_en,
   input logic                   array_act,
   input logic [ROW_W-1:0]       array_row,
   input logic                   write_mode,
   input logic                   rd_start,
   input logic                   rd_hit,
   input logic                   cref_start,
   input logic [ROW_W-1:0]       row_in,
   input logic [ROW_W-1:0]       ref_cnt,
   input logic [NBANK*ROW_W-1:0] tag_vec,
   input logic [NBANK-1:0]       valid_vec
);

   p_wr_blocks_dq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      write_mode |-> !dq_en);

   p_oe_blocks_dq_r9: assert property (@(posedge clk) disable iff (!rst_n)
      oe_n |-> !dq_en);

   p_hit_no_act_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && rd_hit) |=> !array_act);

   p_miss_act_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_start && !rd_hit) |=> (array_act && array_row == $past(row_in)));

   p_act_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
      array_act |=> !array_act);

   p_cnt_row_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cref_start |=> (array_act && array_row == $past(ref_cnt)));

   p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
      cref_start |=> (ref_cnt == ROW_W'($past(ref_cnt) + 1'b1)));

   p_tags_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_start |=> ($stable(tag_vec) && $stable(valid_vec)));

endmodule

bind cdram_row_cache cdram_row_cache_chk #(.ROW_W(ROW_W), .NBANK(NBANK)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .oe_n      (oe_n),
   .dq_en     (dq_en),
   .array_act (array_act),
   .array_row (array_row),
   .write_mode(write_mode),
   .rd_start  (rd_start),
   .rd_hit    (rd_hit),
   .cref_start(cref_start),
   .row_in    (row_in),
   .ref_cnt   (ref_cnt),
   .tag_vec   (tag_vec),
   .valid_vec (valid_vec)
);

// File: tb/tb_cdram_row_cache.sv
`timescale 1ns/1ps
module tb_cdram_row_cache;

   localparam int ROW_W = 2;
   localparam int COL_W = 9;
   localparam int DATA_W = 8;
   localparam int ROWS = 4;
   localparam int COLS = 512;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic row_stb_n = 1'b1, col_stb_n = 1'b1, wr_rd = 1'b0, ref_n = 1'b1;
   logic we_n = 1'b1, oe_n = 1'b1;
   logic [COL_W-1:0]  addr = '0;
   logic [DATA_W-1:0] wdata = '0;
   logic [DATA_W-1:0] dq_o;
   logic dq_en, array_act;
   logic [ROW_W-1:0] array_row;

   int total = 0, bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cdram_row_cache dut (
      .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
      .wr_rd(wr_rd), .ref_n(ref_n), .we_n(we_n), .oe_n(oe_n), .addr(addr),
      .wdata(wdata), .dq_o(dq_o), .dq_en(dq_en), .array_act(array_act),
      .array_row(array_row)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
      end
   endtask

   // behavioural reference, updated at every rising edge
   int m_dram [ROWS][COLS];
   int m_cache [2][COLS];
   int m_tag [2];
   bit m_valid [2];
   int m_ab, m_hcol, m_hdata, m_open, m_arow, m_cnt;
   bit m_wm, m_wprev, m_prow, m_act;

   always begin
      @(posedge clk);
      if (!rst_n) begin
         foreach (m_dram[r, c]) m_dram[r][c] = 0;
         foreach (m_cache[b, c]) m_cache[b][c] = 0;
         m_tag = '{0, 0}; m_valid = '{0, 0};
         m_ab = 0; m_hcol = 0; m_hdata = 0; m_open = 0; m_arow = 0; m_cnt = 0;
         m_wm = 0; m_wprev = 0; m_prow = 1; m_act = 0;
      end else begin
         int col, cw, row, b;
         bit fall, wcond;
         col = col_stb_n ? int'(addr) : m_hcol;
         cw = m_cache[m_ab][col];
         row = int'(addr[ROW_W-1:0]);
         fall = m_prow && !row_stb_n;
         wcond = m_wm && !col_stb_n && !we_n;
         if (wcond && !m_wprev) begin
            m_dram[m_open][col] = int'(wdata);
            b = m_open >> 1;
            if (m_valid[b] && m_tag[b] == m_open) m_cache[b][col] = int'(wdata);
         end
         m_act = 0;
         if (fall) begin
            if (!ref_n) begin
               m_act = 1; m_arow = m_cnt; m_cnt = (m_cnt + 1) % ROWS;
            end else if (wr_rd) begin
               m_open = row; m_act = 1; m_arow = row;
            end else begin
               b = row >> 1;
               m_ab = b;
               if (!(m_valid[b] && m_tag[b] == row)) begin
                  for (int c = 0; c < COLS; c++) m_cache[b][c] = m_dram[row][c];
                  m_tag[b] = row; m_valid[b] = 1; m_act = 1; m_arow = row;
               end
            end
         end
         if (row_stb_n) m_wm = 0;
         else if (fall && ref_n && wr_rd) m_wm = 1;
         m_wprev = wcond;
         m_prow = row_stb_n;
         if (col_stb_n) m_hcol = int'(addr);
         else m_hdata = cw;
      end
      #1;
      begin
         int col, raw, exp_dq;
         bit en;
         col = col_stb_n ? int'(addr) : m_hcol;
         raw = col_stb_n ? m_hdata : m_cache[m_ab][col];
         en = !oe_n && !m_wm;
         exp_dq = en ? raw : 0;
         chk(dq_o == DATA_W'(exp_dq), "R2 dq_o model", int'(dq_o), exp_dq);
         chk(dq_en == en, "R9 dq_en model", int'(dq_en), int'(en));
         chk(array_act == m_act, "R3 array_act model", int'(array_act), int'(m_act));
         chk(int'(array_row) == m_arow, "R8 array_row model", int'(array_row), m_arow);
      end
   end

   // stimulus helpers
   task automatic sample();
      @(posedge clk); #2;
   endtask

   task automatic row_start(input bit is_wr, input bit cref, input int row);
      @(negedge clk);
      addr = COL_W'(row); wr_rd = is_wr; ref_n = !cref; row_stb_n = 1'b0;
      sample();
   endtask

   task automatic row_end();
      @(negedge clk);
      row_stb_n = 1'b1; wr_rd = 1'b0; ref_n = 1'b1; we_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic col_write(input int col, input int data);
      @(negedge clk);
      addr = COL_W'(col); col_stb_n = 1'b1; we_n = 1'b1; wdata = DATA_W'(data);
      @(negedge clk);
      col_stb_n = 1'b0; we_n = 1'b0;
      @(negedge clk);
      col_stb_n = 1'b1; we_n = 1'b1;
   endtask

   task automatic col_read(input int col);
      @(negedge clk);
      addr = COL_W'(col); col_stb_n = 1'b1;
      @(negedge clk);
      col_stb_n = 1'b0;
      sample();
   endtask

   initial begin
      #(5.0 * 20000);
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      sample();
      chk(dq_en == 1'b0 && array_act == 1'b0 && array_row == '0, "R10 reset outputs",
          {dq_en, array_act, array_row}, 0);
      @(negedge clk);
      rst_n = 1'b1;
      oe_n = 1'b0;

      // preload the array
      row_start(1'b1, 1'b0, 0);
      chk(dq_en == 1'b0, "R9 no drive in write cycle", int'(dq_en), 0);
      col_write(5, 'hA5);
      col_write(6, 'h66);
      row_end();
      row_start(1'b1, 1'b0, 2);
      col_write(5, 'h5A);
      row_end();

      // read miss on row 0
      row_start(1'b0, 1'b0, 0);
      chk(array_act && array_row == 0, "R3 miss activation", {array_act, array_row}, 4);
      col_read(5);
      chk(dq_o == 8'hA5, "R5 written word read back", int'(dq_o), 'hA5);
      @(negedge clk); addr = 9'd6;
      sample();
      chk(dq_o == 8'hA5, "R1 column held while strobe low", int'(dq_o), 'hA5);
      @(negedge clk); col_stb_n = 1'b1;
      sample();
      chk(dq_o == 8'hA5, "R2 data held while strobe high", int'(dq_o), 'hA5);
      @(negedge clk); col_stb_n = 1'b0;
      sample();
      chk(dq_o == 8'h66, "R1 column passed while strobe high", int'(dq_o), 'h66);
      @(negedge clk); col_stb_n = 1'b1;
      row_end();

      // read hit
      row_start(1'b0, 1'b0, 0);
      chk(array_act == 1'b0, "R4 hit skips array", int'(array_act), 0);
      row_end();

      // write into the cached row
      row_start(1'b1, 1'b0, 0);
      col_write(5, 'h3C);
      row_end();
      col_read(5);
      chk(dq_o == 8'h3C, "R6 cached word updated", int'(dq_o), 'h3C);
      @(negedge clk); col_stb_n = 1'b1;

      // row-only refresh on row 1 with write enable low
      row_start(1'b1, 1'b0, 1);
      @(negedge clk); we_n = 1'b0; wdata = 8'hFF; addr = 9'd5;
      repeat (3) @(negedge clk);
      row_end();
      col_read(5);
      chk(dq_o == 8'h3C, "R7 cache kept after row-only refresh", int'(dq_o), 'h3C);
      @(negedge clk); col_stb_n = 1'b1;
      row_start(1'b0, 1'b0, 0);
      chk(array_act == 1'b0, "R7 recorded row kept", int'(array_act), 0);
      row_end();

      // counter refresh with cache reads during it
      row_start(1'b0, 1'b1, 3);
      chk(array_act && array_row == 0, "R8 first counter row", {array_act, array_row}, 4);
      col_read(6);
      chk(dq_o == 8'h66, "R8 cache read during refresh", int'(dq_o), 'h66);
      @(negedge clk); col_stb_n = 1'b1;
      row_end();
      row_start(1'b0, 1'b1, 3);
      chk(array_act && array_row == 1, "R8 counter stepped", {array_act, array_row}, 5);
      row_end();

      // second bank
      row_start(1'b0, 1'b0, 2);
      chk(array_act && array_row == 2, "R11 other bank miss", {array_act, array_row}, 6);
      col_read(5);
      chk(dq_o == 8'h5A, "R11 other bank data", int'(dq_o), 'h5A);
      @(negedge clk); col_stb_n = 1'b1;
      row_end();
      row_start(1'b0, 1'b0, 0);
      chk(array_act == 1'b0, "R11 first bank kept", int'(array_act), 0);
      col_read(5);
      chk(dq_o == 8'h3C, "R11 back to first bank", int'(dq_o), 'h3C);
      @(negedge clk); col_stb_n = 1'b1;
      row_end();

      // output enable off
      oe_n = 1'b1;
      col_read(5);
      chk(dq_en == 1'b0 && dq_o == '0, "R9 output disabled", {dq_en, dq_o}, 0);
      @(negedge clk); col_stb_n = 1'b1; oe_n = 1'b0;

      // one write per strobe pulse
      row_start(1'b1, 1'b0, 0);
      @(negedge clk); addr = 9'd6; wdata = 8'h77;
      @(negedge clk); col_stb_n = 1'b0; we_n = 1'b0;
      @(negedge clk); wdata = 8'h11;
      @(negedge clk); wdata = 8'h22;
      @(negedge clk); col_stb_n = 1'b1; we_n = 1'b1;
      row_end();
      col_read(6);
      chk(dq_o == 8'h77, "R5 single write per pulse", int'(dq_o), 'h77);
      @(negedge clk); col_stb_n = 1'b1;
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule